// File: doc/BRIEF.md
# Multiplicative Segment Identifier Scrambler

This block turns a context number and an effective address into a scrambled virtual segment identifier. It first forms a proto identifier by placing the context above the effective-segment bits of the address. It then multiplies that identifier by a fixed 24-bit prime and reduces the product modulo 2^n − 1. The reduction uses a fold with an end-around carry, so no divider is needed. The width n is chosen per request from the segment size and from whether the reduced 65-bit virtual address mode is active.

Requests enter through a valid/ready handshake and results leave through another one. The pipeline has a fixed depth of three register stages. When the output is blocked, the whole pipeline stalls. A result of zero means "no valid identifier". An address outside the allowed range yields zero directly. The proto identifier 2^n − 1 also reduces to zero; a flag marks that case so that a caller can tell it apart from an out-of-range request.

Top module: `vsid_scrambler`

## Requirements
- R1: The proto identifier is `(ctx_i << W) | ((ea_i >> S) & (2^W − 1))`, where S is 28 when `seg_1t_i` is 0 (256 MB segments) and 40 when it is 1 (1 TB segments), and W = 68 − S − 19 (21 or 9).
- R2: The reduction width n is (68 − S) when `va65_i` is 0 and (65 − S) when it is 1, giving 40, 28, 37 or 25.
- R3: With P = proto × 12538073, x = (P >> n) + (P mod 2^n), the result is `vsid_o = (x + ((x + 1) >> n)) mod 2^n`, zero-extended to 40 bits.
- R4: A proto identifier equal to 2^n − 1 produces `vsid_o` = 0 with `zero_flag_o` = 1; whenever `zero_flag_o` is 1, `vsid_o` is 0.
- R5: If `ea_i` with its top 4 bits cleared is greater than or equal to `limit_i`, the result is 0 and `zero_flag_o` is 0.
- R6: A proto identifier of 0 within range yields 0 with `zero_flag_o` = 0.
- R7: With `out_ready` held high, a request accepted at a rising edge appears on `out_valid` after the third rising edge, counting the accepting one; `in_ready` is 1 whenever `out_valid` is 0.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `vsid_o`, `zero_flag_o` and `out_valid` hold their values.
- R9: Results leave in the order of acceptance, with none lost or duplicated under any `out_ready` pattern.
- R10: After synchronous reset, `out_valid` and `zero_flag_o` are 0 and `in_ready` is 1. This also holds when reset is applied with the pipeline full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request taken on this edge if valid |
| ctx_i | input | 19 | Context number |
| ea_i | input | 64 | Effective address |
| seg_1t_i | input | 1 | 0: 256 MB segment, 1: 1 TB segment |
| va65_i | input | 1 | 1: reduced 65-bit address mode |
| limit_i | input | 64 | Exclusive upper bound for the masked address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result on this edge |
| vsid_o | output | 40 | Scrambled identifier, 0 when invalid |
| zero_flag_o | output | 1 | In-range nonzero proto reduced to 0 |

## Verification
Two things can happen in the same edge: a new request enters while the finished result at the output is handed over. Several requests also sit in flight when `out_ready` drops. A streaming run keeps `in_valid` high and switches `out_ready` on a repeating pattern, so that accepts and handovers coincide on some edges and stalls fall in between. Every result handed over is compared, in order, with an independent model of the scramble. The run ends only when each request has come out exactly once.

// File: rtl/vsid_scr_pkg.sv
package vsid_scr_pkg;

    localparam int CTX_W     = 19;
    localparam int EA_W      = 64;
    localparam int VA_FULL   = 68;
    localparam int VA_RED    = 65;
    localparam int SH_SMALL  = 28;
    localparam int SH_LARGE  = 40;
    localparam int REGION_W  = 4;
    localparam int MULT_W    = 24;
    localparam int PROTO_W   = VA_FULL - SH_SMALL;
    localparam int PROD_W    = PROTO_W + MULT_W;
    localparam int NW        = $clog2(PROTO_W + 1);

    localparam logic [MULT_W-1:0] MULT = 24'd12538073;

    typedef enum logic {
        SEG_256M = 1'b0,
        SEG_1T   = 1'b1
    } seg_e;

    // Per-request control that travels beside the datapath
    typedef struct packed {
        logic [NW-1:0] n;       // reduction width
        logic          oor;     // address out of range
        logic          nz;      // proto identifier nonzero
    } side_t;

    function automatic int seg_shift(seg_e s);
        return (s == SEG_1T) ? SH_LARGE : SH_SMALL;
    endfunction

    function automatic int esid_width(seg_e s);
        return VA_FULL - seg_shift(s) - CTX_W;
    endfunction

    function automatic logic [NW-1:0] id_width(seg_e s, logic reduced);
        int top;
        top = reduced ? VA_RED : VA_FULL;
        return NW'(top - seg_shift(s));
    endfunction

endpackage

// File: rtl/vsid_proto_gen.sv
module vsid_proto_gen
    import vsid_scr_pkg::*;
(
    input  logic [CTX_W-1:0]   ctx_i,
    input  logic [EA_W-1:0]    ea_i,
    input  logic               seg_1t_i,
    input  logic               va65_i,
    input  logic [EA_W-1:0]    limit_i,
    output logic [PROTO_W-1:0] proto_o,
    output side_t              side_o
);
    seg_e               seg;
    logic [NW-1:0]      sh;
    logic [NW-1:0]      ew;
    logic [PROTO_W-1:0] esid_mask;
    logic [PROTO_W-1:0] ea_seg;
    logic [EA_W-1:0]    ea_masked;

    assign seg = seg_e'(seg_1t_i);

    always_comb begin
        sh        = NW'(seg_shift(seg));
        ew        = NW'(esid_width(seg));
        esid_mask = (PROTO_W'(1) << ew) - PROTO_W'(1);
        ea_seg    = PROTO_W'(ea_i >> sh);
        proto_o   = (PROTO_W'(ctx_i) << ew) | (ea_seg & esid_mask);
        ea_masked = ea_i & {{REGION_W{1'b0}}, {(EA_W-REGION_W){1'b1}}};
        side_o.n   = id_width(seg, va65_i);
        side_o.oor = (ea_masked >= limit_i);
        side_o.nz  = |proto_o;
    end
endmodule

// File: rtl/vsid_mul_pipe.sv
module vsid_mul_pipe
    import vsid_scr_pkg::*;
#(
    parameter int SLICES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               v_i,
    input  logic [PROTO_W-1:0] a_i,
    input  side_t              side_i,
    output logic               v_o,
    output logic [PROD_W-1:0]  prod_o,
    output side_t              side_o
);
    localparam int SW   = (PROTO_W + SLICES - 1) / SLICES;
    localparam int PADW = SW * SLICES;
    localparam int PPW  = SW + MULT_W;

    logic [PADW-1:0]  a_pad;
    logic [PPW-1:0]   pp_q [SLICES];
    logic             v1_q;
    side_t            s1_q;
    logic [PROD_W-1:0] sum;

    assign a_pad = PADW'(a_i);

    // Stage 1: one partial product per slice of the proto identifier
    for (genvar g = 0; g < SLICES; g++) begin : g_slice
        always_ff @(posedge clk) begin
            if (rst)
                pp_q[g] <= '0;
            else if (en)
                pp_q[g] <= PPW'(a_pad[g*SW +: SW]) * PPW'(MULT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            s1_q <= '0;
        end else if (en) begin
            v1_q <= v_i;
            s1_q <= side_i;
        end
    end

    // Stage 2: weighted sum of the partial products
    always_comb begin
        sum = '0;
        for (int i = 0; i < SLICES; i++)
            sum = sum + (PROD_W'(pp_q[i]) << (i * SW));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o    <= 1'b0;
            prod_o <= '0;
            side_o <= '0;
        end else if (en) begin
            v_o    <= v1_q;
            prod_o <= sum;
            side_o <= s1_q;
        end
    end
endmodule

// File: rtl/vsid_fold_reduce.sv
module vsid_fold_reduce
    import vsid_scr_pkg::*;
(
    input  logic [PROD_W-1:0]  prod_i,
    input  logic [NW-1:0]      n_i,
    output logic [PROTO_W-1:0] res_o
);
    localparam int XW = PROD_W + 1;

    logic [XW-1:0] mask;
    logic [XW-1:0] x;
    logic [XW-1:0] t;

    always_comb begin
        mask  = (XW'(1) << n_i) - XW'(1);
        x     = XW'(prod_i >> n_i) + (XW'(prod_i) & mask);
        t     = x + ((x + XW'(1)) >> n_i);
        res_o = PROTO_W'(t & mask);
    end
endmodule

// File: rtl/vsid_scrambler.sv
module vsid_scrambler
    import vsid_scr_pkg::*;
#(
    parameter int MUL_SLICES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [CTX_W-1:0]   ctx_i,
    input  logic [EA_W-1:0]    ea_i,
    input  logic               seg_1t_i,
    input  logic               va65_i,
    input  logic [EA_W-1:0]    limit_i,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PROTO_W-1:0] vsid_o,
    output logic               zero_flag_o
);
    logic               adv;
    logic [PROTO_W-1:0] proto;
    side_t              side_in;
    logic               mv;
    logic [PROD_W-1:0]  prod;
    side_t              mside;
    logic [PROTO_W-1:0] folded;

    // Whole pipeline moves when the output slot is free or being emptied
    assign adv      = !out_valid || out_ready;
    assign in_ready = adv;

    vsid_proto_gen u_proto (
        .ctx_i    (ctx_i),
        .ea_i     (ea_i),
        .seg_1t_i (seg_1t_i),
        .va65_i   (va65_i),
        .limit_i  (limit_i),
        .proto_o  (proto),
        .side_o   (side_in)
    );

    vsid_mul_pipe #(.SLICES(MUL_SLICES)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .en     (adv),
        .v_i    (in_valid),
        .a_i    (proto),
        .side_i (side_in),
        .v_o    (mv),
        .prod_o (prod),
        .side_o (mside)
    );

    vsid_fold_reduce u_fold (
        .prod_i (prod),
        .n_i    (mside.n),
        .res_o  (folded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            vsid_o      <= '0;
            zero_flag_o <= 1'b0;
        end else if (adv) begin
            out_valid   <= mv;
            vsid_o      <= mside.oor ? '0 : folded;
            zero_flag_o <= mv && !mside.oor && mside.nz && (folded == '0);
        end
    end
endmodule

// File: rtl/vsid_scrambler_chk.sv
module vsid_scrambler_chk
    import vsid_scr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [PROTO_W-1:0] vsid_o,
    input logic               zero_flag_o
);
    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(vsid_o) && $stable(zero_flag_o));

    // R8
    stall_in_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    // R4
    flag_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && zero_flag_o |-> vsid_o == '0);

    // R7
    empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);
endmodule

bind vsid_scrambler vsid_scrambler_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .vsid_o      (vsid_o),
    .zero_flag_o (zero_flag_o)
);

// File: tb/vsid_scrambler_test.sv
module vsid_scrambler_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [18:0] ctx_i = '0;
    logic [63:0] ea_i = '0;
    logic        seg_1t_i = 1'b0;
    logic        va65_i = 1'b0;
    logic [63:0] limit_i = '1;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [39:0] vsid_o;
    logic        zero_flag_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    vsid_scrambler uut (.*);

    typedef struct packed {
        logic        seg;
        logic        red;
        logic [18:0] ctx;
        logic [63:0] ea;
        logic [63:0] lim;
        logic [3:0]  req;
        logic        hand;
        logic [39:0] exp;
        logic        expf;
    } vec_t;

    localparam logic [63:0] LMAX = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 19'h00000, 64'h0000_0000_1000_0000, LMAX, 4'd1, 1'b1, 40'hBF50D9, 1'b0},
        '{1'b1, 1'b0, 19'h00000, 64'h0000_0100_0000_0000, LMAX, 4'd1, 1'b1, 40'hBF50D9, 1'b0},
        '{1'b1, 1'b0, 19'h7FFFF, 64'h0001_FF00_0000_0000, LMAX, 4'd4, 1'b1, 40'h0, 1'b1},
        '{1'b0, 1'b1, 19'h0FFFF, 64'h0001_FFFF_F000_0000, LMAX, 4'd4, 1'b1, 40'h0, 1'b1},
        '{1'b1, 1'b1, 19'h0FFFF, 64'h0001_FF00_0000_0000, LMAX, 4'd4, 1'b1, 40'h0, 1'b1},
        '{1'b0, 1'b0, 19'h00123, 64'h0000_0000_1000_0000, 64'h0000_0000_1000_0000, 4'd5, 1'b1, 40'h0, 1'b0},
        '{1'b0, 1'b0, 19'h00000, 64'hF000_0000_1000_0000, 64'h0000_0000_2000_0000, 4'd5, 1'b1, 40'hBF50D9, 1'b0},
        '{1'b0, 1'b0, 19'h00000, 64'h0000_0000_0000_0000, LMAX, 4'd6, 1'b1, 40'h0, 1'b0},
        '{1'b0, 1'b0, 19'h12345, 64'h0000_0ABC_D000_0000, LMAX, 4'd3, 1'b0, 40'h0, 1'b0},
        '{1'b1, 1'b0, 19'h5A5A5, 64'h0000_3C00_0000_0000, LMAX, 4'd2, 1'b0, 40'h0, 1'b0},
        '{1'b0, 1'b1, 19'h00F0F, 64'h0000_0123_4000_0000, LMAX, 4'd2, 1'b0, 40'h0, 1'b0},
        '{1'b1, 1'b1, 19'h01234, 64'h0000_AB00_0000_0000, LMAX, 4'd2, 1'b0, 40'h0, 1'b0},
        '{1'b0, 1'b0, 19'h7FFFF, 64'h0001_FFFF_F000_0000, LMAX, 4'd4, 1'b1, 40'h0, 1'b1},
        '{1'b1, 1'b0, 19'h00001, 64'h0000_FF00_0000_0000, 64'h0000_FF00_0000_0000, 4'd5, 1'b1, 40'h0, 1'b0},
        '{1'b1, 1'b0, 19'h00001, 64'h0000_FF00_0000_0000, 64'h0000_FF00_0000_0001, 4'd5, 1'b0, 40'h0, 1'b0}
    };

    // Independent model: R1 proto, R2 width, R3 fold, R5 range, R4/R6 flag
    function automatic logic [40:0] model(vec_t v);
        int s, w, n;
        logic [127:0] pr, p, m, x, t, em;
        logic flag;
        s  = v.seg ? 40 : 28;
        w  = 68 - s - 19;
        n  = (v.red ? 65 : 68) - s;
        em = (128'd1 << w) - 1;
        pr = (128'(v.ctx) << w) | ((128'(v.ea) >> s) & em);
        p  = pr * 128'd12538073;
        m  = (128'd1 << n) - 1;
        x  = (p >> n) + (p & m);
        t  = (x + ((x + 1) >> n)) & m;
        if ((v.ea & 64'h0FFF_FFFF_FFFF_FFFF) >= v.lim)
            return 41'd0;
        flag = (pr != 0) && (t == 0);
        return {flag, t[39:0]};
    endfunction

    task automatic check(input string what, input int req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic load(vec_t v);
        ctx_i    = v.ctx;
        ea_i     = v.ea;
        seg_1t_i = v.seg;
        va65_i   = v.red;
        limit_i  = v.lim;
    endtask

    // One request through an idle pipe, with latency checks (R7)
    task automatic run_one(int i);
        logic [40:0] m;
        m = model(VEC[i]);
        @(negedge clk);
        load(VEC[i]);
        in_valid  = 1'b1;
        out_ready = 1'b1;
        #1 check("in_ready idle", 7, 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check("valid after edge 1", 7, 64'(out_valid), 64'd0);
        @(negedge clk);
        check("valid after edge 2", 7, 64'(out_valid), 64'd0);
        @(negedge clk);
        check("valid after edge 3", 7, 64'(out_valid), 64'd1);
        check("vsid vs model", int'(VEC[i].req), 64'(vsid_o), 64'(m[39:0]));
        check("flag vs model", int'(VEC[i].req), 64'(zero_flag_o), 64'(m[40]));
        if (VEC[i].hand) begin
            check("vsid vs table", int'(VEC[i].req), 64'(vsid_o), 64'(VEC[i].exp));
            check("flag vs table", int'(VEC[i].req), 64'(zero_flag_o), 64'(VEC[i].expf));
        end
        @(negedge clk);
        check("drained", 7, 64'(out_valid), 64'd0);
    endtask

    // Back-to-back traffic with toggling out_ready (R8, R9)
    task automatic run_stream();
        int sent = 0;
        int recv = 0;
        logic [39:0] held = '0;
        bit was_stalled = 0;
        for (int cyc = 0; cyc < 400 && recv < NV; cyc++) begin
            @(negedge clk);
            if (was_stalled)
                check("held value", 8, 64'(vsid_o), 64'(held));
            out_ready = (cyc % 3) != 1 && (cyc % 7) != 3;
            in_valid  = sent < NV;
            if (sent < NV) load(VEC[sent]);
            #1;
            was_stalled = out_valid && !out_ready;
            held = vsid_o;
            if (was_stalled)
                check("stall in_ready", 8, 64'(in_ready), 64'd0);
            if (in_valid && in_ready) sent++;
            if (out_valid && out_ready) begin
                logic [40:0] m;
                m = model(VEC[recv]);
                check("stream vsid order", 9, 64'(vsid_o), 64'(m[39:0]));
                check("stream flag order", 9, 64'(zero_flag_o), 64'(m[40]));
                recv++;
            end
        end
        check("stream count", 9, 64'(recv), 64'(NV));
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
    endtask

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("reset valid", 10, 64'(out_valid), 64'd0);
        check("reset flag", 10, 64'(zero_flag_o), 64'd0);
        check("reset ready", 10, 64'(in_ready), 64'd1);

        for (int i = 0; i < NV; i++)
            run_one(i);

        run_stream();

        // R10 reset with the pipe full and output stalled
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        load(VEC[2]);
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        check("full before reset", 10, 64'(out_valid), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("valid after reset", 10, 64'(out_valid), 64'd0);
        check("flag after reset", 10, 64'(zero_flag_o), 64'd0);
        check("ready after reset", 10, 64'(in_ready), 64'd1);
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        check("no ghost output", 10, 64'(out_valid), 64'd0);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL R7 watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule